// File: doc/BRIEF.md
# Multi-Cycle Stored-Program Processor Core

This block is a small processor that runs programs held in a unified word memory of 256 entries, 16 bits wide, shared by code and data. It keeps sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Each instruction passes through three phases in order: fetch, decode and execute. There is no overlap between instructions, so every instruction takes exactly three clock cycles.

An instruction word holds a 4-bit operation code in bits 15:12. The other twelve bits are read as three nibbles: bits 11:8, bits 7:4 and bits 3:0. Depending on the operation code they name registers, an 8-bit address or immediate (bits 7:0), or a rotate count.

A test environment fills memory through a preload port while reset is held. After reset is released, the core runs from address 0 until it halts. A read-only debug view gives the program counter and any one register, selected by index. The preload address also drives a second read port of the memory, so the memory contents can be read back.

Top module: `spc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to its initial state: program counter 0, all registers 0, `halted` 0, `fault` 0, and the next phase is fetch.
- R2: Every instruction takes exactly three cycles. The program counter has advanced by one after the first (fetch) edge. A register is written only at the third (execute) edge. A two-instruction program ending in halt raises `halted` at the sixth edge after reset and not before.
- R3: Code 0x1 (bits 11:8 = R, bits 7:0 = A) loads R with the low 8 bits of memory word A. Code 0x2 loads R with the immediate bits 7:0. Code 0x3 writes R to word A, with bits 15:8 cleared.
- R4: Code 0x4 copies the register named by bits 7:4 into the register named by bits 3:0.
- R5: Code 0x5 writes to register bits 11:8 the 8-bit two's-complement sum, modulo 256, of the registers named by bits 7:4 and bits 3:0.
- R6: Codes 0x7, 0x8 and 0x9 write to register bits 11:8 the bitwise OR, AND and XOR, respectively, of the registers named by bits 7:4 and bits 3:0.
- R7: Code 0xA rotates the register named by bits 11:8 to the right, in place, by the count in bits 3:0 modulo 8. Bits leaving bit 0 re-enter at bit 7.
- R8: Code 0xB loads the program counter with bits 7:0 when the register named by bits 11:8 equals register 0. Otherwise execution continues with the next word.
- R9: Code 0xD always loads the program counter with bits 7:0.
- R10: Code 0xC stops the core with `halted` high and `fault` low. The program counter is left at the address after the halt word.
- R11: Codes 0x0, 0x6, 0xE and 0xF stop the core with both `halted` and `fault` high. The illegal word has no other effect.
- R12: Once halted, the core stays halted until reset. The program counter, the registers and the memory do not change.
- R13: While `ld_en` is high, `ld_data` is written to word `ld_addr` at the rising edge. `mem_rd_data` always shows the word at `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 8 | Preload write and read-back address |
| ld_data | input | 16 | Preload write data |
| mem_rd_data | output | 16 | Memory word at `ld_addr` |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on an illegal operation code |
| dbg_sel | input | 4 | Register index for the debug view |
| dbg_reg | output | 8 | Value of the selected register |
| dbg_pc | output | 8 | Current program counter |

## Verification
The bench uses the default parameters: 8-bit data, sixteen registers and 256 words. With these values every nibble of an instruction names a real register and every 8-bit address reaches a real word. This lets the bench drive the add wrap past 0xFF and reach register 15. It also covers rotate counts of 0, 3 and 9, where 9 must act as 1. Two complete programs check the final memory contents: a load, add and store sequence, and a countdown loop that ends in a taken conditional jump.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int NIB_W  = 4;
    localparam int INST_W = 4 * NIB_W;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * NIB_W;
    localparam int NREG   = 1 << NIB_W;

    localparam logic [NIB_W-1:0] OP_LDM = 4'h1;
    localparam logic [NIB_W-1:0] OP_LDI = 4'h2;
    localparam logic [NIB_W-1:0] OP_STM = 4'h3;
    localparam logic [NIB_W-1:0] OP_MOV = 4'h4;
    localparam logic [NIB_W-1:0] OP_ADD = 4'h5;
    localparam logic [NIB_W-1:0] OP_OR  = 4'h7;
    localparam logic [NIB_W-1:0] OP_AND = 4'h8;
    localparam logic [NIB_W-1:0] OP_XOR = 4'h9;
    localparam logic [NIB_W-1:0] OP_ROR = 4'hA;
    localparam logic [NIB_W-1:0] OP_JEQ = 4'hB;
    localparam logic [NIB_W-1:0] OP_HLT = 4'hC;
    localparam logic [NIB_W-1:0] OP_JMP = 4'hD;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   pc;
        logic [INST_W-1:0]   ir;
        logic                halted;
        logic                fault;
    } core_state_t;
endpackage

// File: rtl/spc_regfile.sv
module spc_regfile #(
    parameter int DW    = 8,
    parameter int NREGS = 16,
    localparam int SW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_b,
    input  logic [SW-1:0] sel_c,
    input  logic [SW-1:0] sel_dbg,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c,
    output logic [DW-1:0] rd_zero,
    output logic [DW-1:0] rd_dbg
);
    logic [DW-1:0] regs_q [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[gi] <= '0;
            else if (we && (wsel == SW'(gi)))
                regs_q[gi] <= wdata;
        end
    end

    assign rd_a    = regs_q[sel_a];
    assign rd_b    = regs_q[sel_b];
    assign rd_c    = regs_q[sel_c];
    assign rd_zero = regs_q[0];
    assign rd_dbg  = regs_q[sel_dbg];
endmodule

// File: rtl/spc_mem.sv
module spc_mem #(
    parameter int AW   = 8,
    parameter int WW   = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [WW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [WW-1:0] rdata_b
);
    logic [WW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells_q[waddr] <= wdata;
    end

    assign rdata_a = cells_q[raddr_a];
    assign rdata_b = cells_q[raddr_b];
endmodule

// File: rtl/spc_alu.sv
module spc_alu
    import spc_pkg::*;
#(
    parameter int DW = 8,
    localparam int SH_W = $clog2(DW)
) (
    input  logic [NIB_W-1:0] op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [NIB_W-1:0] rot_amt,
    output logic [DW-1:0]    result
);
    logic [SH_W-1:0]  sh;
    logic [2*DW-1:0]  dbl;

    always_comb begin
        sh  = rot_amt[SH_W-1:0];
        dbl = {a, a} >> sh;
        unique case (op)
            OP_ADD:  result = a + b;
            OP_OR:   result = a | b;
            OP_AND:  result = a & b;
            OP_XOR:  result = a ^ b;
            OP_ROR:  result = dbl[DW-1:0];
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/spc_core.sv
module spc_core
    import spc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int IW = INST_W,
    localparam int RSW = NIB_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_en,
    input  logic [AW-1:0]  ld_addr,
    input  logic [IW-1:0]  ld_data,
    output logic [IW-1:0]  mem_rd_data,
    output logic           halted,
    output logic           fault,
    input  logic [RSW-1:0] dbg_sel,
    output logic [DW-1:0]  dbg_reg,
    output logic [AW-1:0]  dbg_pc
);
    core_state_t cs_q, cs_d;

    logic [NIB_W-1:0] op_w, fld_r, fld_s, fld_t;
    logic [AW-1:0]    fld_addr;
    logic [DW-1:0]    rd_a, rd_b, rd_c, rd_zero, alu_y, alu_a;
    logic             rf_we;
    logic [RSW-1:0]   rf_wsel;
    logic [DW-1:0]    rf_wdata;
    logic             core_we, mem_we;
    logic [AW-1:0]    core_addr, mem_waddr;
    logic [IW-1:0]    core_wdata, mem_wdata, core_rdata;

    assign op_w     = cs_q.ir[IW-1 -: NIB_W];
    assign fld_r    = cs_q.ir[3*NIB_W-1 -: NIB_W];
    assign fld_s    = cs_q.ir[2*NIB_W-1 -: NIB_W];
    assign fld_t    = cs_q.ir[NIB_W-1:0];
    assign fld_addr = cs_q.ir[AW-1:0];

    spc_regfile #(.DW(DW), .NREGS(1 << RSW)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
        .sel_a(fld_r), .sel_b(fld_s), .sel_c(fld_t), .sel_dbg(dbg_sel),
        .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .rd_zero(rd_zero), .rd_dbg(dbg_reg)
    );

    assign alu_a = (op_w == OP_ROR) ? rd_a : rd_b;

    spc_alu #(.DW(DW)) u_alu (
        .op(op_w), .a(alu_a), .b(rd_c), .rot_amt(fld_t), .result(alu_y)
    );

    assign mem_we    = ld_en | core_we;
    assign mem_waddr = ld_en ? ld_addr : core_addr;
    assign mem_wdata = ld_en ? ld_data : core_wdata;

    spc_mem #(.AW(AW), .WW(IW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(core_addr), .rdata_a(core_rdata),
        .raddr_b(ld_addr), .rdata_b(mem_rd_data)
    );

    always_comb begin
        cs_d       = cs_q;
        rf_we      = 1'b0;
        rf_wsel    = fld_r;
        rf_wdata   = '0;
        core_we    = 1'b0;
        core_wdata = {{(IW-DW){1'b0}}, rd_a};
        core_addr  = (cs_q.phase == PH_FETCH) ? cs_q.pc : fld_addr;
        if (!cs_q.halted) begin
            unique case (cs_q.phase)
                PH_FETCH: begin
                    cs_d.ir    = core_rdata;
                    cs_d.pc    = cs_q.pc + 1'b1;
                    cs_d.phase = PH_DECODE;
                end
                PH_DECODE: cs_d.phase = PH_EXEC;
                default: begin
                    cs_d.phase = PH_FETCH;
                    unique case (op_w)
                        OP_LDM: begin rf_we = 1'b1; rf_wdata = core_rdata[DW-1:0]; end
                        OP_LDI: begin rf_we = 1'b1; rf_wdata = fld_addr[DW-1:0]; end
                        OP_STM: core_we = 1'b1;
                        OP_MOV: begin rf_we = 1'b1; rf_wsel = fld_t; rf_wdata = rd_b; end
                        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: begin
                            rf_we    = 1'b1;
                            rf_wdata = alu_y;
                        end
                        OP_JEQ: if (rd_a == rd_zero) cs_d.pc = fld_addr;
                        OP_JMP: cs_d.pc = fld_addr;
                        OP_HLT: cs_d.halted = 1'b1;
                        default: begin
                            cs_d.halted = 1'b1;
                            cs_d.fault  = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q.phase  <= PH_FETCH;
            cs_q.pc     <= '0;
            cs_q.ir     <= '0;
            cs_q.halted <= 1'b0;
            cs_q.fault  <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign halted = cs_q.halted;
    assign fault  = cs_q.fault;
    assign dbg_pc = cs_q.pc;

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q.halted |=> cs_q.halted);

    // R12
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q.halted |=> $stable(cs_q.pc));

    // R12
    halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q.halted |-> (!rf_we && !core_we));

    // R11
    fault_has_halt_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q.fault |-> cs_q.halted);

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_q.halted && cs_q.phase == PH_FETCH) |=> (cs_q.phase == PH_DECODE));

    // R2
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_q.halted && cs_q.phase == PH_FETCH) |=> (cs_q.pc == $past(cs_q.pc) + 1'b1));

    // R2
    write_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we || core_we) |-> (cs_q.phase == PH_EXEC));
endmodule

// File: tb/tb_spc_core.sv
module tb_spc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem_rd_data;
    logic        halted, fault;
    logic [3:0]  dbg_sel = '0;
    logic [7:0]  dbg_reg, dbg_pc;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [15:0] prog [0:15];
    int plen = 0;

    spc_core dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .mem_rd_data(mem_rd_data), .halted(halted), .fault(fault),
        .dbg_sel(dbg_sel), .dbg_reg(dbg_reg), .dbg_pc(dbg_pc)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int i, output logic [7:0] v);
        dbg_sel = 4'(i);
        #1;
        v = dbg_reg;
    endtask

    task automatic read_mem(input int a, output logic [15:0] v);
        ld_addr = 8'(a);
        #1;
        v = mem_rd_data;
    endtask

    task automatic chk_reg(input int i, input logic [7:0] exp, input string req);
        logic [7:0] v;
        read_reg(i, v);
        chk(v == exp, req, v, exp);
    endtask

    // Hold reset, clear memory, write prog[0..plen-1], release reset at a negedge.
    task automatic load_and_start();
        @(negedge clk);
        rst = 1'b1;
        ld_en = 1'b1;
        for (int a = 0; a < 256; a++) begin
            ld_addr = 8'(a);
            ld_data = (a < plen) ? prog[a] : 16'h0000;
            @(negedge clk);
        end
        ld_en = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wait_halt(output int n);
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        plen = 0;
        load_and_start();
        chk(dbg_pc == 8'h00, "R1 pc", dbg_pc, 0);
        chk(!halted && !fault, "R1 flags", {halted, fault}, 0);
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            chk(v == 8'h00, "R1 reg", v, 0);
        end
    endtask

    task automatic t_preload();
        logic [15:0] v;
        prog[0] = 16'hC000; prog[1] = 16'h1234; prog[2] = 16'hBEEF; plen = 3;
        load_and_start();
        read_mem(1, v); chk(v == 16'h1234, "R13 word1", v, 16'h1234);
        read_mem(2, v); chk(v == 16'hBEEF, "R13 word2", v, 16'hBEEF);
        read_mem(3, v); chk(v == 16'h0000, "R13 word3", v, 0);
    endtask

    task automatic t_timing();
        prog[0] = 16'h2281; prog[1] = 16'hC000; plen = 2;
        load_and_start();
        @(negedge clk);
        chk(dbg_pc == 8'h01, "R2 pc after fetch", dbg_pc, 1);
        chk_reg(2, 8'h00, "R2 no write in fetch");
        @(negedge clk);
        chk_reg(2, 8'h00, "R2 no write in decode");
        @(negedge clk);
        chk_reg(2, 8'h81, "R2 write at exec");
        @(negedge clk); @(negedge clk);
        chk(!halted, "R2 halted early", halted, 0);
        @(negedge clk);
        chk(halted, "R2 halted at edge 6", halted, 1);
        chk(!fault, "R10 no fault", fault, 0);
        chk(dbg_pc == 8'h02, "R10 pc after halt", dbg_pc, 2);
    endtask

    task automatic t_add_prog();
        int n;
        logic [15:0] v;
        prog[0] = 16'h1506; prog[1] = 16'h1607; prog[2] = 16'h5056; prog[3] = 16'h3008;
        prog[4] = 16'hC000; prog[5] = 16'h0001; prog[6] = 16'h0002; prog[7] = 16'h0003;
        plen = 8;
        load_and_start();
        wait_halt(n);
        chk(n == 15, "R2 five instructions", n, 15);
        read_mem(8, v);
        chk(v == 16'h0005, "R3 store cell8", v, 5);
        chk_reg(5, 8'h02, "R3 load mem");
        chk_reg(0, 8'h05, "R5 add");
        chk(dbg_pc == 8'h05, "R10 pc", dbg_pc, 5);
    endtask

    task automatic t_loop_prog();
        int n;
        logic [15:0] v;
        prog[0] = 16'h20FF; prog[1] = 16'h2102; prog[2] = 16'h2200; prog[3] = 16'h130A;
        prog[4] = 16'h5223; prog[5] = 16'h5110; prog[6] = 16'hB108; prog[7] = 16'hD004;
        prog[8] = 16'h320A; prog[9] = 16'hC000; prog[10] = 16'h0003;
        plen = 11;
        load_and_start();
        wait_halt(n);
        read_mem(10, v);
        chk(v == 16'h0009, "R8 loop result", v, 9);
        chk_reg(1, 8'hFF, "R5 add wrap");
        chk(n == 3 * (4 + 3 * 4 - 1 + 2), "R9 loop cycles", n, 51);
    endtask

    task automatic t_logic();
        int n;
        prog[0] = 16'h213C; prog[1] = 16'h220F; prog[2] = 16'h7312; prog[3] = 16'h8412;
        prog[4] = 16'h9512; prog[5] = 16'h4016; prog[6] = 16'h27FF; prog[7] = 16'h2802;
        prog[8] = 16'h5978; prog[9] = 16'h2FAB; prog[10] = 16'h40FE; prog[11] = 16'hC000;
        plen = 12;
        load_and_start();
        wait_halt(n);
        chk_reg(3, 8'h3F, "R6 or");
        chk_reg(4, 8'h0C, "R6 and");
        chk_reg(5, 8'h33, "R6 xor");
        chk_reg(6, 8'h3C, "R4 move");
        chk_reg(14, 8'hAB, "R4 move r15");
        chk_reg(9, 8'h01, "R5 ff plus 2");
    endtask

    task automatic t_rotate();
        int n;
        prog[0] = 16'h2281; prog[1] = 16'hA203; prog[2] = 16'h2381; prog[3] = 16'hA309;
        prog[4] = 16'h2481; prog[5] = 16'hA400; prog[6] = 16'hC000;
        plen = 7;
        load_and_start();
        wait_halt(n);
        chk_reg(2, 8'h30, "R7 ror3");
        chk_reg(3, 8'hC0, "R7 ror9");
        chk_reg(4, 8'h81, "R7 ror0");
    endtask

    task automatic t_branch();
        int n;
        prog[0] = 16'h2005; prog[1] = 16'h2105; prog[2] = 16'hB106; prog[3] = 16'h2277;
        prog[4] = 16'hC000; prog[5] = 16'h0000; prog[6] = 16'h2388; prog[7] = 16'h2404;
        prog[8] = 16'hB40F; prog[9] = 16'h2511; prog[10] = 16'hD00C; prog[11] = 16'h26EE;
        prog[12] = 16'hC000;
        plen = 13;
        load_and_start();
        wait_halt(n);
        chk_reg(2, 8'h00, "R8 taken skips");
        chk_reg(3, 8'h88, "R8 target runs");
        chk_reg(5, 8'h11, "R8 not taken falls through");
        chk_reg(6, 8'h00, "R9 jump skips");
        chk(dbg_pc == 8'h0D, "R9 pc", dbg_pc, 13);
        chk(!fault, "R10 clean halt", fault, 0);
    endtask

    task automatic t_illegal(input logic [3:0] code);
        int n;
        prog[0] = 16'h2107; prog[1] = {code, 12'h123}; prog[2] = 16'h2109; prog[3] = 16'hC000;
        plen = 4;
        load_and_start();
        wait_halt(n);
        chk(halted && fault, "R11 fault halt", {halted, fault}, 3);
        chk(dbg_pc == 8'h02, "R11 pc", dbg_pc, 2);
        chk_reg(1, 8'h07, "R11 no later exec");
    endtask

    task automatic t_frozen();
        int n;
        logic [15:0] v;
        prog[0] = 16'h2105; prog[1] = 16'hC000; prog[2] = 16'h3108; prog[3] = 16'h2177;
        plen = 4;
        load_and_start();
        wait_halt(n);
        repeat (20) @(negedge clk);
        chk(halted, "R12 stays halted", halted, 1);
        chk(dbg_pc == 8'h02, "R12 pc frozen", dbg_pc, 2);
        chk_reg(1, 8'h05, "R12 reg frozen");
        read_mem(8, v);
        chk(v == 16'h0000, "R12 mem frozen", v, 0);
    endtask

    initial begin
        t_reset();
        t_preload();
        t_timing();
        t_add_prog();
        t_loop_prog();
        t_logic();
        t_rotate();
        t_branch();
        t_illegal(4'h6);
        t_illegal(4'hE);
        t_illegal(4'hF);
        t_illegal(4'h0);
        t_frozen();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=below 100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule